// File: doc/BRIEF.md
# Two-Tier Receiver Gain Sequencer

This controller sets the gain of a receive chain from two digitized signal-strength codes. The front-end stages (low-noise amplifier, mixer and first programmable amplifier) get a coarse setting chosen from five modes. The later stages (second programmable amplifier and ADC buffer) share one fine gain word. Both strength detectors produce codes all the time. The controller decides which code it takes at each step of its flow, and it acts only on a code that comes with its valid strobe.

When the receiver is enabled, the controller applies the weakest-signal coarse mode and then takes one code from the first detector. Four ascending threshold inputs place that code in a band, and the band selects the coarse mode. The strongest band is a special case. The controller applies a middle mode, takes a second code from the first detector, and chooses among the three strongest modes from that code. Once the coarse mode is fixed, the controller reads only the second detector. It moves the fine word one step per reading until a reading falls inside a target window, and then it reports lock. If the fine stage runs through its iteration budget without reaching the window, the whole flow starts again from the weakest mode.

Top module: `gain_ladder_ctrl`

## Requirements
- R1: While `rx_en` is low, the outputs show coarse mode 1, the fine word equals FINE_INIT (2^(FINE_W-1)) and `locked` is 0. Strobes are ignored in this state. After `rx_en` rises, the first strobe taken is one that arrives at least one clock after the rise.
- R2: Coarse gain encodings: `lna_gain` is 2 for max, 1 for mid and 0 for min, and it never takes the value 3. `mix_gain_hi` and `pga1_gain_hi` are 1 for max and 0 for min. The modes map as follows. Mode 1: LNA max, mixer max, PGA1 max. Mode 2: max, max, min. Mode 3: mid, min, max. Mode 4: mid, min, min. Mode 5: min, min, min.
- R3: `coarse_thr` packs thr0 in bits [7:0], thr1 in [15:8], thr2 in [23:16] and thr3 in [31:24]. The first detector-A code selects the mode as follows: code < thr0 gives mode 1; thr0 <= code < thr1 gives mode 2; thr1 <= code < thr2 gives mode 3. The new mode is visible one clock after the strobe.
- R4: A first code >= thr2 applies mode 3 and then waits for a second detector-A code. That code selects mode 3 if it is below thr2, mode 4 if it is at least thr2 and below thr3, and mode 5 if it is at least thr3.
- R5: Detector-B strobes have no effect until the coarse mode is fixed. Detector-A strobes have no effect once it is fixed. A code that changes without its strobe has no effect.
- R6: In the fine stage, a detector-B code above `win_hi` lowers the fine word by one, and a code below `win_lo` raises it by one. The word moves at most one step per strobe. `pga2_gain` carries the upper FINE_W-FINE_W/2 bits of the word and `buf_gain` carries the lower FINE_W/2 bits.
- R7: The fine word saturates. A raise at 2^FINE_W-1 and a lower at 0 leave it unchanged.
- R8: A detector-B code with `win_lo` <= code <= `win_hi` sets `locked` one clock later. The coarse and fine gains then stay frozen and every strobe is ignored until `rx_en` falls.
- R9: The MAX_ITER-th out-of-window detector-B code in one fine stage does not step the word. Instead it restarts the flow: mode 1, fine word FINE_INIT, `locked` 0, and the next detector-A code is classified as a first reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the controller idle |
| sense_a_code | input | CODE_W | Strength code from detector A (front of chain) |
| sense_a_vld | input | 1 | Strobe marking a fresh detector-A code |
| sense_b_code | input | CODE_W | Strength code from detector B (after the later stages) |
| sense_b_vld | input | 1 | Strobe marking a fresh detector-B code |
| coarse_thr | input | 4*CODE_W | Four ascending band thresholds, thr0 in the low byte |
| win_lo | input | CODE_W | Lower edge of the target window (inclusive) |
| win_hi | input | CODE_W | Upper edge of the target window (inclusive) |
| lna_gain | output | 2 | LNA gain: 2 max, 1 mid, 0 min |
| mix_gain_hi | output | 1 | Mixer gain: 1 max, 0 min |
| pga1_gain_hi | output | 1 | PGA1 gain: 1 max, 0 min |
| pga2_gain | output | FINE_W-FINE_W/2 | Upper part of the fine gain word |
| buf_gain | output | FINE_W/2 | Lower part of the fine gain word |
| locked | output | 1 | Fine stage has converged |

## Verification
The bench drives codes that sit exactly on each threshold and on both window edges. A design with a strict comparison in place of an inclusive one would land one mode too low there, or would miss lock at the window edge. It drives the fine word into both rails. A design without saturation would wrap from 15 to 0, or from 0 to 15. It sends detector-B strobes during the coarse stage and detector-A strobes after the coarse mode is fixed, which catches a design that listens to the wrong detector. It also runs the iteration budget out exactly, so an off-by-one restart shows up as one extra step or as a missing return to mode 1.

// File: rtl/gain_ladder_pkg.sv
package gain_ladder_pkg;

  typedef enum logic [2:0] {
    CM_1 = 3'd1,
    CM_2 = 3'd2,
    CM_3 = 3'd3,
    CM_4 = 3'd4,
    CM_5 = 3'd5
  } coarse_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_REPROBE,
    ST_FINE,
    ST_LOCKED
  } seq_state_t;

  localparam logic [1:0] LNA_MIN = 2'd0;
  localparam logic [1:0] LNA_MID = 2'd1;
  localparam logic [1:0] LNA_MAX = 2'd2;

  typedef struct packed {
    logic [1:0] lna;
    logic       mix_hi;
    logic       pga1_hi;
  } front_gain_t;

  // ge[i] is set when the code is at or above threshold i.
  function automatic coarse_mode_t pick_first(input logic [3:0] ge);
    if (ge[1])      return CM_3;
    else if (ge[0]) return CM_2;
    else            return CM_1;
  endfunction

  function automatic coarse_mode_t pick_second(input logic [3:0] ge);
    if (ge[3])      return CM_5;
    else if (ge[2]) return CM_4;
    else            return CM_3;
  endfunction

  function automatic front_gain_t map_mode(input coarse_mode_t m);
    front_gain_t g;
    case (m)
      CM_1:    g = '{lna: LNA_MAX, mix_hi: 1'b1, pga1_hi: 1'b1};
      CM_2:    g = '{lna: LNA_MAX, mix_hi: 1'b1, pga1_hi: 1'b0};
      CM_3:    g = '{lna: LNA_MID, mix_hi: 1'b0, pga1_hi: 1'b1};
      CM_4:    g = '{lna: LNA_MID, mix_hi: 1'b0, pga1_hi: 1'b0};
      default: g = '{lna: LNA_MIN, mix_hi: 1'b0, pga1_hi: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/gain_band_classifier.sv
module gain_band_classifier
  import gain_ladder_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int N_THR  = 4
) (
  input  logic [CODE_W-1:0]       code,
  input  logic [N_THR*CODE_W-1:0] thr_flat,
  output coarse_mode_t            first_mode,
  output coarse_mode_t            second_mode,
  output logic                    strong_band
);

  logic [N_THR-1:0] ge;

  for (genvar i = 0; i < N_THR; i++) begin : g_cmp
    assign ge[i] = (code >= thr_flat[i*CODE_W +: CODE_W]);
  end

  assign first_mode  = pick_first(ge);
  assign second_mode = pick_second(ge);
  assign strong_band = ge[2];

endmodule

// File: rtl/fine_gain_stepper.sv
module fine_gain_stepper #(
  parameter int CODE_W = 8,
  parameter int FINE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] win_lo,
  input  logic [CODE_W-1:0] win_hi,
  input  logic [FINE_W-1:0] fine_cur,
  output logic              in_window,
  output logic [FINE_W-1:0] fine_next
);

  localparam logic [FINE_W-1:0] FINE_TOP = {FINE_W{1'b1}};

  function automatic logic [FINE_W-1:0] step_word(
    input logic [FINE_W-1:0] cur,
    input logic              up,
    input logic              down
  );
    if (up && cur != FINE_TOP)    return cur + 1'b1;
    if (down && cur != '0)        return cur - 1'b1;
    return cur;
  endfunction

  logic too_weak, too_strong;

  assign too_weak   = (code < win_lo);
  assign too_strong = (code > win_hi);
  assign in_window  = !too_weak && !too_strong;
  assign fine_next  = step_word(fine_cur, too_weak, too_strong);

endmodule

// File: rtl/front_gain_decoder.sv
module front_gain_decoder
  import gain_ladder_pkg::*;
(
  input  coarse_mode_t mode,
  output logic [1:0]   lna_gain,
  output logic         mix_gain_hi,
  output logic         pga1_gain_hi
);

  front_gain_t g;

  assign g            = map_mode(mode);
  assign lna_gain     = g.lna;
  assign mix_gain_hi  = g.mix_hi;
  assign pga1_gain_hi = g.pga1_hi;

endmodule

// File: rtl/gain_ladder_ctrl.sv
module gain_ladder_ctrl
  import gain_ladder_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int FINE_W   = 6,
  parameter int MAX_ITER = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_en,
  input  logic [CODE_W-1:0]            sense_a_code,
  input  logic                         sense_a_vld,
  input  logic [CODE_W-1:0]            sense_b_code,
  input  logic                         sense_b_vld,
  input  logic [4*CODE_W-1:0]          coarse_thr,
  input  logic [CODE_W-1:0]            win_lo,
  input  logic [CODE_W-1:0]            win_hi,
  output logic [1:0]                   lna_gain,
  output logic                         mix_gain_hi,
  output logic                         pga1_gain_hi,
  output logic [FINE_W-FINE_W/2-1:0]   pga2_gain,
  output logic [FINE_W/2-1:0]          buf_gain,
  output logic                         locked
);

  localparam int HALF_W = FINE_W / 2;
  localparam int ITER_W = $clog2(MAX_ITER + 1);
  localparam logic [FINE_W-1:0] FINE_INIT = FINE_W'(1) << (FINE_W - 1);
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER - 1);

  seq_state_t         state_q;
  coarse_mode_t       mode_q;
  logic [FINE_W-1:0]  fine_q;
  logic [ITER_W-1:0]  iter_q;
  logic               locked_q;

  coarse_mode_t       first_mode, second_mode;
  logic               strong_band;
  logic               in_window;
  logic [FINE_W-1:0]  fine_next;

  // Named events used by the FSM and by the bound checker.
  logic in_fine_stage, take_first, take_second, take_fine;
  logic hit_evt, miss_evt, restart_evt;

  assign in_fine_stage = (state_q == ST_FINE);
  assign take_first    = (state_q == ST_PROBE)   && sense_a_vld;
  assign take_second   = (state_q == ST_REPROBE) && sense_a_vld;
  assign take_fine     = in_fine_stage && sense_b_vld;
  assign hit_evt       = take_fine && in_window;
  assign miss_evt      = take_fine && !in_window;
  assign restart_evt   = miss_evt && (iter_q == ITER_LAST);

  gain_band_classifier #(.CODE_W(CODE_W), .N_THR(4)) u_class (
    .code        (sense_a_code),
    .thr_flat    (coarse_thr),
    .first_mode  (first_mode),
    .second_mode (second_mode),
    .strong_band (strong_band)
  );

  fine_gain_stepper #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_step (
    .code      (sense_b_code),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .fine_cur  (fine_q),
    .in_window (in_window),
    .fine_next (fine_next)
  );

  front_gain_decoder u_dec (
    .mode         (mode_q),
    .lna_gain     (lna_gain),
    .mix_gain_hi  (mix_gain_hi),
    .pga1_gain_hi (pga1_gain_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= CM_1;
      fine_q   <= FINE_INIT;
      iter_q   <= '0;
      locked_q <= 1'b0;
    end else if (!rx_en) begin
      state_q  <= ST_IDLE;
      mode_q   <= CM_1;
      fine_q   <= FINE_INIT;
      iter_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: state_q <= ST_PROBE;
        ST_PROBE: begin
          if (take_first) begin
            mode_q  <= first_mode;
            state_q <= strong_band ? ST_REPROBE : ST_FINE;
          end
        end
        ST_REPROBE: begin
          if (take_second) begin
            mode_q  <= second_mode;
            state_q <= ST_FINE;
          end
        end
        ST_FINE: begin
          if (hit_evt) begin
            locked_q <= 1'b1;
            state_q  <= ST_LOCKED;
          end else if (restart_evt) begin
            state_q <= ST_PROBE;
            mode_q  <= CM_1;
            fine_q  <= FINE_INIT;
            iter_q  <= '0;
          end else if (miss_evt) begin
            fine_q <= fine_next;
            iter_q <= iter_q + 1'b1;
          end
        end
        default: state_q <= ST_LOCKED;
      endcase
    end
  end

  assign pga2_gain = fine_q[FINE_W-1:HALF_W];
  assign buf_gain  = fine_q[HALF_W-1:0];
  assign locked    = locked_q;

endmodule

// File: rtl/gain_ladder_checker.sv
module gain_ladder_checker #(
  parameter int FINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic [1:0]        lna_gain,
  input logic              mix_gain_hi,
  input logic              pga1_gain_hi,
  input logic              locked,
  input logic [FINE_W-1:0] fine_word,
  input logic              in_fine_stage,
  input logic              restart_evt
);

  localparam logic [FINE_W-1:0] FTOP = {FINE_W{1'b1}};

  // R1: disabled receiver shows mode 1 and no lock
  p_idle_mode1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!locked && lna_gain == 2'd2 && mix_gain_hi && pga1_gain_hi));

  // R2: LNA code 3 is never produced
  p_lna_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lna_gain != 2'd3);

  // R5: fine word untouched outside the fine stage
  p_b_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !in_fine_stage) |=> $stable(fine_word));

  // R6: at most one step per cycle unless restarting
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !restart_evt) |=>
      (fine_word == $past(fine_word) ||
       fine_word == $past(fine_word) + 1'b1 ||
       fine_word == $past(fine_word) - 1'b1));

  // R7: no wrap at either rail
  p_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !restart_evt && fine_word == FTOP) |=> fine_word != '0);

  p_no_wrap_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !restart_evt && fine_word == '0) |=> fine_word != FTOP);

  // R8: lock holds and freezes the gains while enabled
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rx_en) |=> (locked && $stable(fine_word) && $stable(lna_gain)));

  // R9: restart returns to mode 1 without lock
  p_restart_mode1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (!locked && lna_gain == 2'd2 && mix_gain_hi && pga1_gain_hi));

endmodule

bind gain_ladder_ctrl gain_ladder_checker #(.FINE_W(FINE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_en         (rx_en),
  .lna_gain      (lna_gain),
  .mix_gain_hi   (mix_gain_hi),
  .pga1_gain_hi  (pga1_gain_hi),
  .locked        (locked),
  .fine_word     (fine_q),
  .in_fine_stage (in_fine_stage),
  .restart_evt   (restart_evt)
);

// File: tb/gain_ladder_ctrl_bench.sv
module gain_ladder_ctrl_bench;

  localparam int CW = 8;
  localparam int FW = 4;
  localparam int MI = 10;
  localparam int FINIT = 8;
  localparam int FTOP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [CW-1:0] a_code = '0, b_code = '0;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic [4*CW-1:0] thr = {8'd200, 8'd150, 8'd100, 8'd50};
  logic [CW-1:0] wlo = 8'd120, whi = 8'd130;
  logic [1:0] lna;
  logic mix, pga1, lock;
  logic [FW-FW/2-1:0] pga2;
  logic [FW/2-1:0] bufg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gain_ladder_ctrl #(.CODE_W(CW), .FINE_W(FW), .MAX_ITER(MI)) u_gain_ladder_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .sense_a_code(a_code), .sense_a_vld(a_vld),
    .sense_b_code(b_code), .sense_b_vld(b_vld),
    .coarse_thr(thr), .win_lo(wlo), .win_hi(whi),
    .lna_gain(lna), .mix_gain_hi(mix), .pga1_gain_hi(pga1),
    .pga2_gain(pga2), .buf_gain(bufg), .locked(lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected front gains packed as lna*4 + mix*2 + pga1
  function automatic int mode_gains(input int m);
    case (m)
      1: return 2*4 + 2 + 1;
      2: return 2*4 + 2 + 0;
      3: return 1*4 + 0 + 1;
      4: return 1*4 + 0 + 0;
      default: return 0;
    endcase
  endfunction

  function automatic int seen_gains();
    return int'(lna) * 4 + int'(mix) * 2 + int'(pga1);
  endfunction

  function automatic int seen_fine();
    return int'({pga2, bufg});
  endfunction

  task automatic restart_seq();
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_a(input int c);
    @(negedge clk) begin a_code = CW'(c); a_vld = 1'b1; end
    @(negedge clk) a_vld = 1'b0;
  endtask

  task automatic pulse_b(input int c);
    @(negedge clk) begin b_code = CW'(c); b_vld = 1'b1; end
    @(negedge clk) b_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset gains", seen_gains(), mode_gains(1));
    check("R1 reset fine", seen_fine(), FINIT);
    check("R1 reset lock", int'(lock), 0);
  endtask

  task automatic t_first_band();
    int codes[5] = '{20, 49, 50, 99, 100};
    int modes[5] = '{1, 1, 2, 2, 3};
    foreach (codes[i]) begin
      restart_seq();
      check("R1 mode1 on enable", seen_gains(), mode_gains(1));
      pulse_a(codes[i]);
      check("R3 first band", seen_gains(), mode_gains(modes[i]));
    end
    restart_seq();
    pulse_a(149);
    check("R3 band top edge", seen_gains(), mode_gains(3));
  endtask

  task automatic t_reread();
    int seconds[4] = '{140, 150, 199, 200};
    int modes[4]   = '{3, 4, 4, 5};
    foreach (seconds[i]) begin
      restart_seq();
      pulse_a(150);
      check("R4 interim mode3", seen_gains(), mode_gains(3));
      pulse_b(0);
      check("R5 B ignored in reprobe", seen_fine(), FINIT);
      pulse_a(seconds[i]);
      check("R4 reread band", seen_gains(), mode_gains(modes[i]));
    end
  endtask

  task automatic t_ignore();
    restart_seq();
    pulse_b(0);
    check("R5 B ignored in probe", seen_fine(), FINIT);
    @(negedge clk) a_code = 8'd120;
    @(negedge clk);
    check("R5 code without strobe", seen_gains(), mode_gains(1));
    pulse_a(120);
    check("R3 mode3", seen_gains(), mode_gains(3));
    pulse_a(255);
    check("R5 A ignored in fine", seen_gains(), mode_gains(3));
    @(negedge clk) b_code = 8'd0;
    @(negedge clk);
    check("R5 B code without strobe", seen_fine(), FINIT);
  endtask

  task automatic t_fine_steps();
    restart_seq();
    pulse_a(20);
    pulse_b(200);
    check("R6 step down", seen_fine(), FINIT - 1);
    check("R6 pga2 field", int'(pga2), (FINIT - 1) >> 2);
    check("R6 buf field", int'(bufg), (FINIT - 1) & 3);
    pulse_b(10);
    check("R6 step up", seen_fine(), FINIT);
    pulse_b(119);
    check("R6 below window edge", seen_fine(), FINIT + 1);
    pulse_b(131);
    check("R6 above window edge", seen_fine(), FINIT);
  endtask

  task automatic t_saturate();
    restart_seq();
    pulse_a(20);
    for (int k = 0; k < 9; k++) pulse_b(0);
    check("R7 top rail", seen_fine(), FTOP);
    restart_seq();
    pulse_a(20);
    for (int k = 0; k < 9; k++) pulse_b(255);
    check("R7 bottom rail", seen_fine(), 0);
    check("R7 no early restart", seen_gains(), mode_gains(1));
  endtask

  task automatic t_lock();
    restart_seq();
    pulse_a(60);
    pulse_b(0);
    pulse_b(120);
    check("R8 lock at win_lo", int'(lock), 1);
    pulse_b(255);
    check("R8 fine frozen", seen_fine(), FINIT + 1);
    pulse_a(255);
    check("R8 coarse frozen", seen_gains(), mode_gains(2));
    restart_seq();
    check("R1 disable clears lock", int'(lock), 0);
    pulse_a(20);
    pulse_b(130);
    check("R8 lock at win_hi", int'(lock), 1);
  endtask

  task automatic t_restart();
    restart_seq();
    pulse_a(120);
    for (int k = 0; k < MI - 1; k++) pulse_b(0);
    check("R9 before budget", seen_fine(), FTOP);
    check("R9 mode kept", seen_gains(), mode_gains(3));
    pulse_b(0);
    check("R9 restart mode1", seen_gains(), mode_gains(1));
    check("R9 restart fine", seen_fine(), FINIT);
    check("R9 restart unlocked", int'(lock), 0);
    pulse_a(160);
    check("R9 reclassified as first", seen_gains(), mode_gains(3));
    pulse_a(210);
    check("R9 reread after restart", seen_gains(), mode_gains(5));
    pulse_b(125);
    check("R9 fresh budget locks", int'(lock), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_band();
    t_reread();
    t_ignore();
    t_fine_steps();
    t_saturate();
    t_lock();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule